// File: doc/BRIEF.md
# Edge-Latched Interrupt Status Controller

This block gathers six synchronous event lines into a six-bit status word and raises one level-sensitive interrupt request for the whole group. Each line has its own enable bit. When a line rises while its enable bit is set, the matching status bit is latched to 1 and stays set. The request is high whenever the status word is non-zero. It therefore rises when the word leaves zero and falls only when the word returns to zero.

There is no separate acknowledge or clear register. Software clears a status bit by writing its enable bit to 0. While an enable bit is 0, the matching status bit is held at 0 and edges on that line are ignored. A simple synchronous register bus with one address bit gives access to both words. Address 0 is the enable register, which can be written and read. Address 1 is the status register, which can only be read.

Top module: `irq_edge_latch`

## Requirements
- R1: There are six source lines. Status bit i (bit 0 = LSB of the 6-bit word) belongs to source line i, and enable bit i controls source line i.
- R2: When source line i is 1 in a cycle, was 0 in the previous cycle, and enable bit i is already 1, status bit i is 1 after that clock edge.
- R3: A falling edge or a line that stays high does not set a status bit. A set bit stays set until it is cleared as in R6.
- R4: The request output irq_o is 1 in every cycle in which the status word is non-zero. It goes from 0 to 1 on the edge where the word goes from zero to non-zero.
- R5: While irq_o is high, further edges on other lines set their status bits and irq_o stays high without dropping. irq_o falls only after every status bit is zero.
- R6: Writing 0 to enable bit i clears status bit i at that same clock edge. Status bits can be cleared in no other way except reset.
- R7: While enable bit i is 0, status bit i reads 0 and rising edges on line i are ignored.
- R8: A rising edge on line i in the same cycle as enable bit i is written from 0 to 1 is not latched.
- R9: A write with reg_addr_i = 0 loads the enable register from reg_wdata_i[5:0]. reg_rdata_o shows the enable register when reg_addr_i = 0 and the status register when reg_addr_i = 1. A write with reg_addr_i = 1 changes nothing.
- R10: Reset (rst_i = 1, synchronous, active high) clears the enable register, the status register and irq_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| src_i | input | 6 | Synchronous event lines |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = enable register, 1 = status register |
| reg_wdata_i | input | 6 | Write data |
| reg_rdata_o | output | 6 | Read data for the selected register |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench raises a line in the same cycle that its enable bit is written to 1. A design that used the new enable value would latch that edge. It holds lines high over several cycles and drops them, which would catch a design that latches levels or falling edges. It adds a second event while the request is already high, and it clears bits one at a time. This shows the request staying high until the last bit goes and never falling early. It also pulses a line whose enable bit is 0 and writes to the status address. A design that leaked disabled edges, or that accepted a clear through the status address, would show a non-zero status or a dropped bit.

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int N_SRC = 6
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [N_SRC-1:0] src_i,
  input  logic             reg_wr_i,
  input  logic             reg_addr_i,
  input  logic [N_SRC-1:0] reg_wdata_i,
  output logic [N_SRC-1:0] reg_rdata_o,
  output logic             irq_o
);

  logic [N_SRC-1:0] en_q, en_d;
  logic [N_SRC-1:0] status_q, status_d;
  logic [N_SRC-1:0] src_q;
  logic [N_SRC-1:0] rise;
  logic             en_wr;

  assign en_wr    = reg_wr_i && !reg_addr_i;
  assign rise     = src_i & ~src_q;
  assign en_d     = en_wr ? reg_wdata_i : en_q;
  // old enable gates the edge, new enable gates the hold
  assign status_d = en_d & (status_q | (rise & en_q));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      en_q     <= '0;
      status_q <= '0;
      src_q    <= '0;
    end else begin
      en_q     <= en_d;
      status_q <= status_d;
      src_q    <= src_i;
    end
  end

  assign irq_o       = |status_q;
  assign reg_rdata_o = reg_addr_i ? status_q : en_q;

  a_r2_edge_latches: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_wr |=> ((status_q & $past(en_q & src_i & ~src_q)) == $past(en_q & src_i & ~src_q)));

  a_r3_no_spurious_set: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(en_q & src_i & ~src_q)) == '0));

  a_r5_irq_holds: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_o && !en_wr) |=> irq_o);

  a_r6_clear_by_enable: assert property (@(posedge clk_i) disable iff (rst_i)
    en_wr |=> ((status_q & ~$past(reg_wdata_i)) == '0));

  a_r7_disabled_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    (status_q & ~en_q) == '0);

  a_r10_reset_clears: assert property (@(posedge clk_i)
    rst_i |=> (status_q == '0 && en_q == '0 && !irq_o));

endmodule

// File: tb/tb_irq_edge_latch.sv
module tb_irq_edge_latch;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] src = '0;
  logic       wr = 1'b0;
  logic       addr = 1'b1;
  logic [5:0] wdata = '0;
  logic [5:0] rdata;
  logic       irq;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irq_edge_latch dut (
    .clk_i(clk), .rst_i(rst), .src_i(src), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  // {wr, wdata, src, exp_status, exp_irq}
  localparam int NV = 17;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 6'h3F, 6'h00, 6'h00, 1'b0},  // R9 enable all
    {1'b0, 6'h00, 6'h01, 6'h01, 1'b1},  // R2 R4 edge on line 0
    {1'b0, 6'h00, 6'h03, 6'h03, 1'b1},  // R5 second edge while high
    {1'b0, 6'h00, 6'h03, 6'h03, 1'b1},  // R3 held high
    {1'b0, 6'h00, 6'h00, 6'h03, 1'b1},  // R3 falling edge
    {1'b1, 6'h3E, 6'h00, 6'h02, 1'b1},  // R6 R5 clear bit 0, irq stays
    {1'b1, 6'h3C, 6'h00, 6'h00, 1'b0},  // R6 R5 last bit cleared
    {1'b1, 6'h3F, 6'h01, 6'h00, 1'b0},  // R8 edge with enable write
    {1'b0, 6'h00, 6'h01, 6'h00, 1'b0},  // R3 held, no new edge
    {1'b0, 6'h00, 6'h21, 6'h20, 1'b1},  // R1 line 5 -> bit 5
    {1'b1, 6'h1F, 6'h21, 6'h00, 1'b0},  // R6 clear bit 5
    {1'b0, 6'h00, 6'h00, 6'h00, 1'b0},
    {1'b0, 6'h00, 6'h20, 6'h00, 1'b0},  // R7 disabled edge ignored
    {1'b1, 6'h3F, 6'h20, 6'h00, 1'b0},  // R7 enable later, no latch
    {1'b0, 6'h00, 6'h00, 6'h00, 1'b0},
    {1'b0, 6'h00, 6'h3F, 6'h3F, 1'b1},  // R1 all lines
    {1'b1, 6'h00, 6'h3F, 6'h00, 1'b0}   // R6 clear all
  };

  task automatic cycle(input logic w, input logic a, input logic [5:0] d, input logic [5:0] s);
    @(negedge clk);
    wr = w; addr = a; wdata = d; src = s;
    @(posedge clk);
    #1;
    wr = 1'b0; addr = 1'b1;
    #0.5;
  endtask

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    addr = 1'b1; #0.5;
    chk("R10 status after reset", rdata, 6'h00);
    chk("R10 irq after reset", {5'b0, irq}, 6'h00);
    addr = 1'b0; #0.5;
    chk("R10 enable after reset", rdata, 6'h00);

    for (int i = 0; i < NV; i++) begin
      cycle(VEC[i][19], 1'b0, VEC[i][18:13], VEC[i][12:7]);
      chk($sformatf("vec %0d status", i), rdata, VEC[i][6:1]);
      chk($sformatf("vec %0d irq R4", i), {5'b0, irq}, {5'b0, VEC[i][0]});
    end

    // R9 enable readback
    cycle(1'b1, 1'b0, 6'h2A, 6'h00);
    addr = 1'b0; #0.5;
    chk("R9 enable readback", rdata, 6'h2A);

    // R9 write to status address ignored
    cycle(1'b0, 1'b0, 6'h00, 6'h02);
    chk("R2 bit1 set", rdata, 6'h02);
    cycle(1'b1, 1'b1, 6'h00, 6'h02);
    chk("R9 status write ignored", rdata, 6'h02);
    addr = 1'b0; #0.5;
    chk("R9 enable unchanged by status write", rdata, 6'h2A);

    // R10 reset mid-operation
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; addr = 1'b1; #0.5;
    chk("R10 status cleared", rdata, 6'h00);
    chk("R10 irq cleared", {5'b0, irq}, 6'h00);
    addr = 1'b0; #0.5;
    chk("R10 enable cleared", rdata, 6'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule